// File: doc/BRIEF.md
# Gray-Coded Multi-Channel Pulse Counter with Snapshot

This block counts rising edges on several asynchronous, clock-like input lines. Each input line directly clocks its own small counter. That counter keeps its state in Gray code, so only one bit changes per step. A separate, stable system clock brings every counter's Gray value into its own domain through a chain of flip-flops. It then converts the synchronized value to binary.

Software or control logic raises a one-cycle snapshot request at the instants it wants counts. On that system-clock edge, every channel's count is latched together. A valid strobe follows for one cycle. The counters run freely and wrap at 2^WIDTH, so a rate is obtained by differencing successive snapshots.

Gray coding limits the cross-domain error. The capture flops may see either the old or the new value of the single changing bit. In both cases the result is a legal count, off by at most one step.

Top module: `pulse_snap_counter`

## Requirements
- R1: Each channel counts rising edges of its own pulse input, modulo 2^WIDTH, starting from zero after reset.
- R2: Channels are independent: edges on one input never change another channel's count.
- R3: The Gray value crossing into the system domain comes straight from a source flop. The synchronized Gray value of a channel changes in at most one bit per system-clock cycle, provided the pulse rate is below the system clock rate.
- R4: A rising edge that occurs between two system-clock edges is first reflected in a snapshot captured on the SYNC_STAGES+1'th system edge after it, and not in any earlier snapshot.
- R5: On a system edge where snap_req is high, all channels' counts are loaded into snap_counts together. snap_valid is then high for the following cycle. Channel c occupies bits [c*WIDTH +: WIDTH].
- R6: While snap_req is low, snap_counts holds its value and snap_valid stays low, whatever the pulse inputs do.
- R7: Driving rst_n low asynchronously clears all counters, all synchronizer stages, snap_counts and snap_valid. The system side leaves reset two system-clock edges after rst_n rises.
- R8: While pulses are arriving, a snapshot value lies between the true count three system cycles before the capture and the true count at the capture, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stable system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | CHANNELS | Asynchronous pulse trains, one per channel, each used as a clock |
| snap_req | input | 1 | Snapshot request, sampled on clk |
| snap_counts | output | CHANNELS*WIDTH | Latched binary counts, channel c at [c*WIDTH +: WIDTH] |
| snap_valid | output | 1 | One-cycle strobe after each captured snapshot |

## Verification
The bench builds the block with three channels, a four-bit counter width and two synchronizer stages. With four bits, every channel wraps more than once within a few dozen bursts, so the modulo rollover and all sixteen Gray codes are exercised. Three channels are enough to drive concurrent trains at different periods and confirm that the channels do not interfere. The two-stage depth makes the capture latency small enough to probe edge by edge. Pulse periods stay slightly longer than the 20 ns system period, which is the condition under which the synchronized Gray value may change only one bit per cycle.

// File: rtl/pcnt_pkg.sv
`timescale 1ns/1ps
package pcnt_pkg;
  // Minimum flop chain depth for crossing Gray bits into the system domain.
  localparam int MIN_SYNC_STAGES = 2;
  // Depth of the reset release synchronizer on the system side.
  localparam int RST_SYNC_STAGES = 2;
endpackage

// File: rtl/pcnt_gray_counter.sv
`timescale 1ns/1ps
// Gray-code up counter clocked directly by a measured pulse line.
module pcnt_gray_counter #(
  parameter int WIDTH = 16
) (
  input  logic             pulse_clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] gray_q
);
  logic [WIDTH-1:0] bin_cur;
  logic [WIDTH-1:0] bin_nxt;
  logic [WIDTH-1:0] gray_d;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      bin_cur[i] = ^(gray_q >> i);
    end
    bin_nxt = bin_cur + WIDTH'(1);
    gray_d  = bin_nxt ^ (bin_nxt >> 1);
  end

  // The crossing value leaves from this register with no logic after it.
  always_ff @(posedge pulse_clk or negedge rst_n) begin
    if (!rst_n) gray_q <= '0;
    else        gray_q <= gray_d;
  end
endmodule

// File: rtl/pcnt_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer chain for a Gray-coded bus.
module pcnt_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = pcnt_pkg::MIN_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pcnt_gray2bin.sv
`timescale 1ns/1ps
// Combinational Gray to binary conversion, system domain only.
module pcnt_gray2bin #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] gray,
  output logic [WIDTH-1:0] bin
);
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      bin[i] = ^(gray >> i);
    end
  end
endmodule

// File: rtl/pcnt_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of the system-side reset.
module pcnt_rst_sync #(
  parameter int STAGES = pcnt_pkg::RST_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/pulse_snap_counter.sv
`timescale 1ns/1ps
// Multi-channel asynchronous pulse counter with synchronized snapshot.
module pulse_snap_counter #(
  parameter int CHANNELS    = 9,
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = pcnt_pkg::MIN_SYNC_STAGES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CHANNELS-1:0]       pulse_in,
  input  logic                      snap_req,
  output logic [CHANNELS*WIDTH-1:0] snap_counts,
  output logic                      snap_valid
);
  localparam int BUS_W = CHANNELS * WIDTH;

  logic             sys_rst_n;
  logic [BUS_W-1:0] sync_gray_all;
  logic [BUS_W-1:0] live_bin;
  logic [BUS_W-1:0] snap_d;
  logic [BUS_W-1:0] snap_q;
  logic             valid_d;
  logic             valid_q;

  pcnt_rst_sync #(.STAGES(pcnt_pkg::RST_SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (sys_rst_n)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [WIDTH-1:0] src_gray;
    logic [WIDTH-1:0] dst_gray;

    pcnt_gray_counter #(.WIDTH(WIDTH)) u_cnt (
      .pulse_clk (pulse_in[c]),
      .rst_n     (rst_n),
      .gray_q    (src_gray)
    );

    pcnt_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .d     (src_gray),
      .q     (dst_gray)
    );

    pcnt_gray2bin #(.WIDTH(WIDTH)) u_cvt (
      .gray (dst_gray),
      .bin  (live_bin[c*WIDTH +: WIDTH])
    );

    assign sync_gray_all[c*WIDTH +: WIDTH] = dst_gray;
  end

  // Next state: load on request, otherwise hold.
  always_comb begin
    snap_d  = snap_req ? live_bin : snap_q;
    valid_d = snap_req;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      snap_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      snap_q  <= snap_d;
      valid_q <= valid_d;
    end
  end

  assign snap_counts = snap_q;
  assign snap_valid  = valid_q;
endmodule

// File: rtl/pulse_snap_counter_chk.sv
`timescale 1ns/1ps
// Property checker bound to pulse_snap_counter.
module pulse_snap_counter_chk #(
  parameter int CHANNELS = 9,
  parameter int WIDTH    = 16
) (
  input logic                      clk,
  input logic                      sys_rst_n,
  input logic                      snap_req,
  input logic                      snap_valid,
  input logic [CHANNELS*WIDTH-1:0] snap_counts,
  input logic [CHANNELS*WIDTH-1:0] sync_gray_all
);
  // R5
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    snap_req |=> snap_valid);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !snap_req |=> (!snap_valid && $stable(snap_counts)));

  // R7
  reset_release_clear_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(sys_rst_n) |-> (!snap_valid && snap_counts == '0));

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch_chk
    // R3
    gray_single_step_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      $countones(sync_gray_all[c*WIDTH +: WIDTH] ^ $past(sync_gray_all[c*WIDTH +: WIDTH])) <= 1);
  end
endmodule

bind pulse_snap_counter pulse_snap_counter_chk #(
  .CHANNELS (CHANNELS),
  .WIDTH    (WIDTH)
) u_chk (
  .clk           (clk),
  .sys_rst_n     (sys_rst_n),
  .snap_req      (snap_req),
  .snap_valid    (snap_valid),
  .snap_counts   (snap_counts),
  .sync_gray_all (sync_gray_all)
);

// File: tb/pulse_snap_counter_bench.sv
`timescale 1ns/1ps
module pulse_snap_counter_bench;
  localparam int CH   = 3;
  localparam int W    = 4;
  localparam int ST   = 2;
  localparam int MASK = (1 << W) - 1;

  logic              clk;
  logic              rst_n;
  logic [CH-1:0]     pulse;
  logic              snap_req;
  logic [CH*W-1:0]   snap_counts;
  logic              snap_valid;

  int tally [CH];
  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  int h1 = 0, h2 = 0, h3 = 0, h4 = 0;

  pulse_snap_counter #(.CHANNELS(CH), .WIDTH(W), .SYNC_STAGES(ST)) u_pulse_snap_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse_in    (pulse),
    .snap_req    (snap_req),
    .snap_counts (snap_counts),
    .snap_valid  (snap_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // History of channel 1's true count at falling edges (for R8).
  always @(negedge clk) begin
    h4 <= h3; h3 <= h2; h2 <= h1; h1 <= tally[1];
  end

  function automatic int chan(input int c);
    return int'(snap_counts[c*W +: W]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_n(input int c, input int n, input int half);
    repeat (n) begin
      pulse[c] = 1'b1;
      tally[c]++;
      #half;
      pulse[c] = 1'b0;
      #half;
    end
  endtask

  task automatic take_snap();
    @(negedge clk); snap_req = 1'b1;
    @(negedge clk); snap_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int prev [CH];
    rst_n = 1'b0; snap_req = 1'b0; pulse = '0;
    for (int c = 0; c < CH; c++) tally[c] = 0;
    #55 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: reset state
    check("R7 valid after reset", int'(snap_valid), 0);
    for (int c = 0; c < CH; c++) check("R7 count after reset", chan(c), 0);

    // R1 R2 R5: concurrent bursts, wrapping several times
    for (int rnd = 0; rnd < 24; rnd++) begin
      #3;
      fork
        pulse_n(0, rnd % 4, 12);
        pulse_n(1, (rnd + 1) % 4, 13);
        pulse_n(2, (rnd * 3 + 2) % 5, 14);
      join
      repeat (4) @(negedge clk);
      take_snap();
      check("R5 valid after request", int'(snap_valid), 1);
      for (int c = 0; c < CH; c++) check("R1 R2 channel count", chan(c), tally[c] & MASK);
      @(negedge clk);
      check("R5 valid single cycle", int'(snap_valid), 0);
    end

    // R6: no request, counts hold
    for (int c = 0; c < CH; c++) prev[c] = chan(c);
    #3 pulse_n(0, 3, 12);
    pulse_n(2, 2, 13);
    repeat (6) @(negedge clk);
    check("R6 valid idle", int'(snap_valid), 0);
    for (int c = 0; c < CH; c++) check("R6 counts held", chan(c), prev[c]);

    // R4: capture latency with snap_req held high
    repeat (4) @(negedge clk);
    prev[0] = tally[0] & MASK;
    snap_req = 1'b1;
    fork
      begin #2 pulse[0] = 1'b1; tally[0]++; #12 pulse[0] = 1'b0; end
    join_none
    @(negedge clk); check("R4 first edge old", chan(0), prev[0]);
    @(negedge clk); check("R4 second edge old", chan(0), prev[0]);
    @(negedge clk); check("R4 third edge new", chan(0), (prev[0] + 1) & MASK);
    snap_req = 1'b0;

    // R8: snapshots during continuous activity
    repeat (2) @(negedge clk);
    fork
      begin #3 pulse_n(1, 45, 12); end
      begin
        for (int k = 0; k < 12; k++) begin
          take_snap();
          #1;
          begin
            int v, up, lo, diff;
            v = chan(1); up = tally[1]; lo = h4;
            diff = (up - v) & MASK;
            vectors++;
            if (diff > up - lo) begin
              errors++;
              $display("FAIL R8 bound: actual %0d expected within [%0d,%0d] mod %0d",
                       v, lo & MASK, up & MASK, MASK + 1);
            end
          end
          @(negedge clk);
        end
      end
    join
    repeat (4) @(negedge clk);
    take_snap();
    check("R8 settled count", chan(1), tally[1] & MASK);

    // R7: reset in the middle of operation
    #3 pulse_n(2, 5, 12);
    rst_n = 1'b0;
    for (int c = 0; c < CH; c++) tally[c] = 0;
    repeat (3) @(negedge clk);
    check("R7 valid during reset", int'(snap_valid), 0);
    for (int c = 0; c < CH; c++) check("R7 count during reset", chan(c), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    take_snap();
    for (int c = 0; c < CH; c++) check("R7 count after re-reset", chan(c), 0);
    #3 pulse_n(1, 2, 12);
    repeat (4) @(negedge clk);
    take_snap();
    check("R1 count restarts from zero", chan(1), 2);

    done = 1;
    finish_run();
  end
endmodule